// File: doc/BRIEF.md
# Sequential Five-Phase Integer Lifting Wavelet Transform

This block performs one level of a forward integer wavelet transform on a single continuous stream of signed samples. Samples arrive over a valid/ready input and are taken in pairs: the first accepted sample of a pair is the even sample and the second is the odd one. One shared three-term multiply-add core is reused for five lifting steps, one step per clock. Each step adds a rounded, coefficient-weighted sum of two operands to the result of the step before it. Six registers carry values from one pair to the next.

Every pair produces one result beat. The beat carries a detail coefficient and an approximation coefficient for the previous pair, plus a flag that marks the first two results after reset. The final normalisation scaling is not applied, so results stay in the integer domain with the input's width. The input is back-pressured: `in_ready` is high only in the two capture cycles. The output holds its beat until `out_ready` is seen, and the fifth step waits for the output slot to be free.

Top module: `dwt_lift_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0, `in_ready` is 1, and every carried register and the warm-up counter read as zero.
- R2: `in_ready` is 1 only in the even-capture and odd-capture states. The first sample accepted after reset or after a result is the even sample and the second is the odd sample. After the odd sample is accepted, `in_ready` stays 0 for five cycles or longer.
- R3: Write Rnd(x) = floor((x + 8) / 16) and Sat() for clamping to the signed 10-bit range. Let e, o be the current pair and ep, op, p1..p4 the values carried from the previous pair. With coefficients c0..c7, the steps are:
  - y1 = Sat(op + Rnd(c0*e))
  - y2 = Sat(y1 + Rnd(c1*ep + c2*p1))
  - y3 = Sat(y2 + Rnd(c3*op + c4*p2))
  - y4 = Sat(y3 + Rnd(c5*ep + c6*p3))
  - y5 = Sat(y4 + Rnd(c7*p4))
- R4: Every step result saturates at 511 and -512 instead of wrapping.
- R5: When a pair completes, the carried registers take the values ep=e, op=o, p1=y1, p2=y2, p3=y3 and p4=y4. Every later pair uses these values.
- R6: Each pair yields exactly one output beat, with `out_detail` = y4 and `out_approx` = y5, both two's complement. When the output slot is free, `out_valid` rises after the sixth rising edge, counting the edge that accepts the odd sample.
- R7: While `out_valid` is 1 and `out_ready` is 0, the beat and its flag hold steady. A following pair stalls in its fifth step with `in_ready` at 0.
- R8: `out_warmup` is 1 on the first two beats after reset and 0 on every later beat.
- R9: Coefficient ci is the signed 6-bit field `COEFS[6i+5:6i]`, scaled by 16. The default values of c0..c7 are -7, 5, -3, 9, 2, -11, 4, 6.
- R10: Cycles with `in_valid` low change no state. A pending even sample keeps waiting with `in_ready` at 1, and no beat appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 10 | Signed input sample |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the beat this cycle |
| out_approx | output | 10 | Signed approximation coefficient |
| out_detail | output | 10 | Signed detail coefficient |
| out_warmup | output | 1 | Beat is one of the first two after reset |

## Verification
An all-zero stream and a constant level test whether the carried state and the rounding offset build up correctly from the zero reset state. A ramp makes each step's two weighted operands differ, so a swapped operand or coefficient changes the result. Alternating full-scale samples drive the step sums past both range limits, which separates saturation from wrap-around. Pseudo-random samples sent with random gaps and an intermittent `out_ready` test the stall paths. Directed sequences measure the six-edge latency, the hold under back-pressure, and the idle wait between an even and an odd sample.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
  // Controller states: two capture slots followed by five lifting steps.
  typedef enum logic [2:0] {
    PH_CAP_E = 3'd0,
    PH_CAP_O = 3'd1,
    PH_1     = 3'd2,
    PH_2     = 3'd3,
    PH_3     = 3'd4,
    PH_4     = 3'd5,
    PH_5     = 3'd6
  } phase_e;

  localparam int N_COEF    = 8;
  localparam int WARM_BEATS = 2;
endpackage

// File: rtl/dwt_coef_rom.sv
module dwt_coef_rom
  import dwt_pkg::*;
#(
  parameter int CW = 6,
  parameter logic [N_COEF*CW-1:0] COEFS = '0
) (
  input  phase_e               phase,
  output logic signed [CW-1:0] coef_a,
  output logic signed [CW-1:0] coef_b
);
  logic signed [CW-1:0] ent [N_COEF];

  for (genvar g = 0; g < N_COEF; g++) begin : g_ent
    assign ent[g] = COEFS[g*CW +: CW];
  end

  // Steps 1 and 5 use one weighted operand; the idle slot gets weight zero.
  always_comb begin
    coef_a = '0;
    coef_b = '0;
    unique case (phase)
      PH_1: begin coef_a = ent[0]; end
      PH_2: begin coef_a = ent[1]; coef_b = ent[2]; end
      PH_3: begin coef_a = ent[3]; coef_b = ent[4]; end
      PH_4: begin coef_a = ent[5]; coef_b = ent[6]; end
      PH_5: begin coef_a = ent[7]; end
      default: begin coef_a = '0; coef_b = '0; end
    endcase
  end
endmodule

// File: rtl/dwt_mac_core.sv
module dwt_mac_core #(
  parameter int DW   = 10,
  parameter int CW   = 6,
  parameter int FRAC = 4   // coefficient scaling as a power of two, at least 1
) (
  input  logic signed [DW-1:0] mid,
  input  logic signed [DW-1:0] op_a,
  input  logic signed [DW-1:0] op_b,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  output logic signed [DW-1:0] res
);
  localparam int PW = DW + CW;
  localparam int SW = PW + 1;
  localparam int TW = SW + 1;
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC - 1);
  localparam logic signed [TW-1:0] HI   = (TW'(1) <<< (DW - 1)) - TW'(1);
  localparam logic signed [TW-1:0] LO   = -HI - TW'(1);

  logic signed [PW-1:0] pa, pb;
  logic signed [SW-1:0] acc, scaled;
  logic signed [TW-1:0] tot;

  always_comb begin
    pa     = PW'(op_a) * PW'(coef_a);
    pb     = PW'(op_b) * PW'(coef_b);
    acc    = SW'(pa) + SW'(pb) + HALF;
    scaled = acc >>> FRAC;
    tot    = TW'(scaled) + TW'(mid);
    if (tot > HI)      res = HI[DW-1:0];
    else if (tot < LO) res = LO[DW-1:0];
    else               res = tot[DW-1:0];
  end
endmodule

// File: rtl/dwt_phase_ctrl.sv
module dwt_phase_ctrl
  import dwt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  logic   slot_free,
  output phase_e phase,
  output logic   in_ready,
  output logic   take_even,
  output logic   take_odd,
  output logic   advance,
  output logic   commit
);
  phase_e nxt;

  always_comb begin
    in_ready  = (phase == PH_CAP_E) || (phase == PH_CAP_O);
    take_even = in_valid && (phase == PH_CAP_E);
    take_odd  = in_valid && (phase == PH_CAP_O);
    commit    = (phase == PH_5) && slot_free;
    advance   = (phase == PH_1) || (phase == PH_2) || (phase == PH_3) ||
                (phase == PH_4) || commit;
    nxt = phase;
    unique case (phase)
      PH_CAP_E: if (take_even) nxt = PH_CAP_O;
      PH_CAP_O: if (take_odd)  nxt = PH_1;
      PH_1:     nxt = PH_2;
      PH_2:     nxt = PH_3;
      PH_3:     nxt = PH_4;
      PH_4:     nxt = PH_5;
      PH_5:     if (commit) nxt = PH_CAP_E;
      default:  nxt = PH_CAP_E;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_CAP_E;
    else        phase <= nxt;
  end
endmodule

// File: rtl/dwt_lift_seq.sv
module dwt_lift_seq
  import dwt_pkg::*;
#(
  parameter int DW   = 10,
  parameter int CW   = 6,
  parameter int FRAC = 4,
  parameter logic [N_COEF*CW-1:0] COEFS =
    {6'sd6, 6'sd4, -6'sd11, 6'sd2, 6'sd9, -6'sd3, 6'sd5, -6'sd7}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_approx,
  output logic [DW-1:0] out_detail,
  output logic          out_warmup
);
  localparam int NW = $clog2(WARM_BEATS + 1);

  phase_e phase;
  logic take_even, take_odd, advance, commit, slot_free;

  // current pair, running step value, and six carried registers
  logic signed [DW-1:0] e_cur, o_cur, chain;
  logic signed [DW-1:0] e_prev, o_prev, p1, p2, p3, p4;

  logic signed [DW-1:0] mid, op_a, op_b, core_res;
  logic signed [CW-1:0] coef_a, coef_b;
  logic [NW-1:0]        n_done;

  assign slot_free = !out_valid || out_ready;

  dwt_phase_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .slot_free (slot_free),
    .phase     (phase),
    .in_ready  (in_ready),
    .take_even (take_even),
    .take_odd  (take_odd),
    .advance   (advance),
    .commit    (commit)
  );

  dwt_coef_rom #(.CW(CW), .COEFS(COEFS)) u_rom (
    .phase  (phase),
    .coef_a (coef_a),
    .coef_b (coef_b)
  );

  // operand routing per step; the previous step result is the unweighted term
  always_comb begin
    mid  = chain;
    op_a = '0;
    op_b = '0;
    unique case (phase)
      PH_1: begin mid = o_prev; op_a = e_cur; end
      PH_2: begin op_a = e_prev; op_b = p1; end
      PH_3: begin op_a = o_prev; op_b = p2; end
      PH_4: begin op_a = e_prev; op_b = p3; end
      PH_5: begin op_a = p4; end
      default: begin mid = chain; end
    endcase
  end

  dwt_mac_core #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_core (
    .mid    (mid),
    .op_a   (op_a),
    .op_b   (op_b),
    .coef_a (coef_a),
    .coef_b (coef_b),
    .res    (core_res)
  );

  // capture registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_cur <= '0;
      o_cur <= '0;
    end else begin
      if (take_even) e_cur <= $signed(in_data);
      if (take_odd)  o_cur <= $signed(in_data);
    end
  end

  // step chain and carried state; each carried value is retired right after
  // its last reader step, so no extra holding registers are needed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      e_prev <= '0;
      o_prev <= '0;
      p1     <= '0;
      p2     <= '0;
      p3     <= '0;
      p4     <= '0;
    end else if (advance) begin
      chain <= core_res;
      unique case (phase)
        PH_2: p1 <= chain;
        PH_3: p2 <= chain;
        PH_4: p3 <= chain;
        PH_5: begin
          p4     <= chain;
          e_prev <= e_cur;
          o_prev <= o_cur;
        end
        default: ;
      endcase
    end
  end

  // output slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_approx <= '0;
      out_detail <= '0;
      out_warmup <= 1'b0;
      n_done     <= '0;
    end else begin
      if (commit) begin
        out_valid  <= 1'b1;
        out_detail <= chain;
        out_approx <= core_res;
        out_warmup <= (n_done < NW'(WARM_BEATS));
        if (n_done < NW'(WARM_BEATS)) n_done <= n_done + NW'(1);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dwt_lift_chk.sv
module dwt_lift_chk
  import dwt_pkg::*;
#(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_approx,
  input logic [DW-1:0] out_detail,
  input logic          out_warmup,
  input phase_e        phase
);
  logic [1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (out_valid && out_ready && seen != 2'd3) seen <= seen + 2'd1;
  end

  AST_ODD_TAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && phase == PH_CAP_O) |=> !in_ready); // R2

  AST_EVEN_TAKE_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && phase == PH_CAP_E) |=> in_ready); // R2

  AST_BEAT_FROM_STEP5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(phase) == PH_5); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_approx) &&
                                   $stable(out_detail) && $stable(out_warmup))); // R7

  AST_WARM_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen < 2'd2) |-> out_warmup); // R8

  AST_WARM_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen >= 2'd2) |-> !out_warmup); // R8

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready)); // R1
endmodule

bind dwt_lift_seq dwt_lift_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_approx (out_approx),
  .out_detail (out_detail),
  .out_warmup (out_warmup),
  .phase      (phase)
);

// File: tb/tb_dwt_lift_seq.sv
module tb_dwt_lift_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [9:0] out_approx, out_detail;
  logic       out_warmup;

  int checks = 0;
  int fails = 0;
  int sat_hits = 0;
  int n_pairs = 0;
  bit rmode = 0;
  bit hold_low = 0;
  int cyc = 0;
  logic [31:0] seed = 32'h1234_abcd;

  int C [8] = '{-7, 5, -3, 9, 2, -11, 4, 6};
  int ep = 0, op = 0, q1 = 0, q2 = 0, q3 = 0, q4 = 0;
  logic [20:0] expq [$];

  always #2 clk = ~clk;

  dwt_lift_seq dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_approx(out_approx), .out_detail(out_detail), .out_warmup(out_warmup)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(int v);
    if (v > 511) return 511;
    if (v < -512) return -512;
    return v;
  endfunction

  function automatic int rnd(int v);
    return (v + 8) >>> 4;
  endfunction

  // reference model from R3/R5/R8/R9
  task automatic model_pair(int e, int o);
    int y1, y2, y3, y4, y5;
    y1 = sat(op + rnd(C[0]*e));
    y2 = sat(y1 + rnd(C[1]*ep + C[2]*q1));
    y3 = sat(y2 + rnd(C[3]*op + C[4]*q2));
    y4 = sat(y3 + rnd(C[5]*ep + C[6]*q3));
    y5 = sat(y4 + rnd(C[7]*q4));
    if (y4 == 511 || y4 == -512 || y5 == 511 || y5 == -512) sat_hits++;
    expq.push_back({(n_pairs < 2), 10'(y5), 10'(y4)});
    n_pairs++;
    ep = e; op = o; q1 = y1; q2 = y2; q3 = y3; q4 = y4;
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic send_sample(int x, int gap);
    in_data  = 10'(x);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_pair(int e, int o, int gap);
    model_pair(e, o);
    send_sample(e, gap);
    send_sample(o, gap);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    out_ready <= hold_low ? 1'b0 : (rmode ? ((cyc % 3) != 0) : 1'b1);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(0, "R6", "unexpected beat", 1, 0);
      end else begin
        logic [20:0] ex;
        ex = expq.pop_front();
        check($signed(out_detail) == $signed(ex[9:0]), "R3 R6", "detail",
              int'($signed(out_detail)), int'($signed(ex[9:0])));
        check($signed(out_approx) == $signed(ex[19:10]), "R3 R5 R9", "approx",
              int'($signed(out_approx)), int'($signed(ex[19:10])));
        check(out_warmup == ex[20], "R8", "warmup flag", int'(out_warmup), int'(ex[20]));
      end
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R6", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [9:0] h_a, h_d;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R2/R6: capture order and latency on the first pair
    model_pair(100, -50);
    send_sample(100, 0);
    check(in_ready == 1'b1, "R2", "ready after even", int'(in_ready), 1);
    send_sample(-50, 0);
    check(in_ready == 1'b0, "R2", "ready after odd", int'(in_ready), 0);
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R6", "valid after 5 edges", int'(out_valid), 0);
    check(in_ready == 1'b0, "R2", "ready during steps", int'(in_ready), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R6", "valid after 6 edges", int'(out_valid), 1);
    check(in_ready == 1'b1, "R2", "ready back after step 5", int'(in_ready), 1);

    // R10: idle gap between even and odd sample
    model_pair(37, 12);
    send_sample(37, 8);
    check(in_ready == 1'b1, "R10", "waiting for odd", int'(in_ready), 1);
    check(out_valid == 1'b0, "R10", "no beat while idle", int'(out_valid), 0);
    send_sample(12, 0);

    // patterns: zeros, constant, ramp, full-scale alternation (R4)
    for (int i = 0; i < 4; i++) send_pair(0, 0, 0);
    for (int i = 0; i < 6; i++) send_pair(200, 200, 0);
    for (int i = 0; i < 10; i++) send_pair(i*40 - 200, i*40 - 180, 0);
    for (int i = 0; i < 8; i++) send_pair(511, -512, 0);
    for (int i = 0; i < 4; i++) send_pair(-512, -512, 0);
    for (int i = 0; i < 4; i++) send_pair(511, 511, 0);

    // random samples, gaps, intermittent out_ready
    rmode = 1;
    for (int i = 0; i < 60; i++) begin
      int a, b;
      seed = seed * 32'd1664525 + 32'd1013904223;
      a = int'(seed[25:16]) - 512;
      seed = seed * 32'd1664525 + 32'd1013904223;
      b = int'(seed[25:16]) - 512;
      send_pair(a, b, int'(seed[3:2]));
    end
    rmode = 0;
    repeat (12) @(negedge clk);

    // R7: back-pressure hold and stall in step 5
    hold_low = 1;
    repeat (2) @(negedge clk);
    send_pair(300, -300, 0);
    repeat (10) @(negedge clk);
    check(out_valid == 1'b1, "R7", "beat pending", int'(out_valid), 1);
    h_a = out_approx;
    h_d = out_detail;
    send_pair(-77, 150, 0);
    repeat (10) @(negedge clk);
    check(in_ready == 1'b0, "R7", "stalled in step 5", int'(in_ready), 0);
    check(out_valid == 1'b1, "R7", "beat still held", int'(out_valid), 1);
    check(out_approx == h_a, "R7", "approx held", int'($signed(out_approx)), int'($signed(h_a)));
    check(out_detail == h_d, "R7", "detail held", int'($signed(out_detail)), int'($signed(h_d)));
    hold_low = 0;

    for (int i = 0; i < 200 && expq.size() != 0; i++) @(negedge clk);
    check(expq.size() == 0, "R6", "all beats delivered", expq.size(), 0);
    check(sat_hits > 0, "R4", "saturating cases exercised", sat_hits, 1);
    finish_run();
  end
endmodule